// File: doc/BRIEF.md
# PWM Time-Base Counter with Two-Stage Prescaler

This block is the timing heart of a pulse-width modulator. A 16-bit counter advances once per prescaled tick and runs in one of four modes: counting up, counting down, counting up then down (triangle), or frozen. The prescaler multiplies a power-of-two ratio by an even ratio, so a slow PWM carrier can be produced from a fast system clock while the period value still fits in 16 bits.

Software programs the block through one 16-bit write port. A select bit chooses between the control word and the period value. The period can be written straight into the active register. It can also be written into a shadow copy that is moved into the active register only when the counter reaches zero, so that a period change never cuts a PWM cycle short. The block outputs the counter value and two one-clock strobes, one for reaching zero and one for reaching the period value. A downstream action block uses these to set, clear or toggle its PWM pins.

Top module: `pwm_timebase`

## Requirements
- R1: Control bits [1:0] select the counting mode: 00 up, 01 down, 10 up-down, 11 freeze. In freeze the count holds its value and neither strobe is raised.
- R2: In up mode each tick adds one to the count. When the count equals or exceeds the active period P, the next tick makes it 0, so one PWM period lasts P+1 ticks. With P = 0 the count stays at 0.
- R3: In down mode each tick subtracts one. When the count is 0, or is above P, the next tick loads P.
- R4: In up-down mode the count rises to P, then falls back to 0, then rises again, so one period lasts 2P ticks. With P = 0 the count stays at 0.
- R5: Control bits [12:10] hold a value A. The first prescaler stage divides the clock by 2 to the power A.
- R6: Control bits [9:7] hold a value B. The second stage divides by 1 when B = 0 and by 2*B otherwise. A tick occurs once every (2^A)*(B ? 2B : 1) clock cycles.
- R7: After each tick that leaves the count at 0, `zero_evt_o` is high for exactly the one clock in which `count_o` first shows that value. After each tick that leaves the count equal to the active period, `prd_evt_o` is high in the same way. Both strobes are low in every other cycle.
- R8: When control bit 3 is 0, a period write (`wr_sel_i` = 1) goes only to the shadow register. The shadow value becomes the active period on the same clock edge where a tick takes the count to 0.
- R9: When control bit 3 is 1, a period write updates both the active period and the shadow period at the clock edge of the write.
- R10: After reset the count is 0, both strobes are low, the mode is freeze, the prescaler ratio is 1, the period load mode is shadowed, and both period registers are 0.
- R11: A control write (`wr_sel_i` = 0) restarts the prescaler from its first phase and sets the up-down direction to rising. The first tick at the new ratio therefore occurs ratio-1 cycles after the write edge. A period write does not restart the prescaler.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe for one register |
| wr_sel_i | input | 1 | 0 selects the control word, 1 selects the period |
| wr_data_i | input | 16 | Write data |
| count_o | output | 16 | Current counter value |
| zero_evt_o | output | 1 | One-clock strobe when a tick leaves the count at 0 |
| prd_evt_o | output | 1 | One-clock strobe when a tick leaves the count equal to the active period |

## Verification
The checker's stepping and shadow-load properties assume that the active period changes only through the block's own update rules. They also assume that no write arrives in the same cycle as a wrap that loads the shadow. The shadow-load property is therefore qualified with `!wr_en_i`. The bench drives at most one write per cycle. Each write is a single-cycle pulse with `wr_en_i` low between writes. The bench's own reference model decides ordering in the same way as the requirements: the tick uses the old control word, and a write overrides a shadow load made at the same edge. Stimulus covers the ratio extremes, a zero period, and period changes made while the counter runs.

// File: rtl/pwm_tbase_pkg.sv
package pwm_tbase_pkg;

    localparam int CNT_W      = 16;
    localparam int DIV_W      = 3;

    // Control word field positions
    localparam int MODE_LSB   = 0;
    localparam int PLOAD_BIT  = 3;
    localparam int DIVB_LSB   = 7;
    localparam int DIVA_LSB   = 10;

    typedef enum logic [1:0] {
        MODE_UP   = 2'b00,
        MODE_DOWN = 2'b01,
        MODE_UPDN = 2'b10,
        MODE_HOLD = 2'b11
    } cnt_mode_e;

    typedef struct packed {
        cnt_mode_e          mode;
        logic               ld_imm;
        logic [DIV_W-1:0]   div_a;
        logic [DIV_W-1:0]   div_b;
    } ctrl_t;

endpackage

// File: rtl/pwm_tbase_prescale.sv
module pwm_tbase_prescale #(
    parameter int DIV_W = 3
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             restart_i,
    input  logic [DIV_W-1:0] div_a_i,
    input  logic [DIV_W-1:0] div_b_i,
    output logic             tick_o
);

    localparam int A_W = (1 << DIV_W) - 1;   // stage A counts up to 2^max-1
    localparam int B_W = DIV_W + 1;          // stage B counts up to 2*max-1

    typedef struct packed {
        logic [A_W-1:0] cnt_a;
        logic [B_W-1:0] cnt_b;
    } ps_state_t;

    ps_state_t      st_d, st_q;
    logic [A_W-1:0] lim_a;
    logic [B_W-1:0] lim_b;
    logic           a_wrap;
    logic           b_last;

    always_comb begin
        lim_a  = A_W'((32'd1 << div_a_i) - 32'd1);
        lim_b  = (div_b_i == '0) ? '0 : B_W'({div_b_i, 1'b0} - 1'b1);
        a_wrap = (st_q.cnt_a == lim_a);
        b_last = (st_q.cnt_b == lim_b);

        st_d = st_q;
        if (restart_i) begin
            st_d.cnt_a = '0;
            st_d.cnt_b = '0;
        end else begin
            st_d.cnt_a = a_wrap ? '0 : st_q.cnt_a + 1'b1;
            if (a_wrap) begin
                st_d.cnt_b = b_last ? '0 : st_q.cnt_b + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tick_o = a_wrap && b_last;

endmodule

// File: rtl/pwm_tbase_period.sv
module pwm_tbase_period #(
    parameter int W = 16
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         wr_i,
    input  logic         imm_i,
    input  logic [W-1:0] data_i,
    input  logic         load_i,
    output logic [W-1:0] active_o,
    output logic [W-1:0] active_nx_o,
    output logic [W-1:0] shadow_o
);

    typedef struct packed {
        logic [W-1:0] act;
        logic [W-1:0] shd;
    } prd_state_t;

    prd_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load_i) begin
            st_d.act = st_q.shd;
        end
        if (wr_i) begin
            st_d.shd = data_i;
            if (imm_i) begin
                st_d.act = data_i;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign active_o    = st_q.act;
    assign active_nx_o = st_d.act;
    assign shadow_o    = st_q.shd;

endmodule

// File: rtl/pwm_tbase_counter.sv
module pwm_tbase_counter
    import pwm_tbase_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         tick_i,
    input  cnt_mode_e    mode_i,
    input  logic         dir_rst_i,
    input  logic [W-1:0] period_i,
    input  logic [W-1:0] period_nx_i,
    output logic         wrap_o,
    output logic [W-1:0] count_o,
    output logic         zero_evt_o,
    output logic         prd_evt_o
);

    typedef struct packed {
        logic [W-1:0] cnt;
        logic         down;
        logic         zero_evt;
        logic         prd_evt;
    } cnt_state_t;

    cnt_state_t   st_d, st_q;
    logic [W-1:0] cnt_nx;
    logic         down_nx;
    logic         step;

    // Next count and direction, independent of the period update
    always_comb begin
        step    = tick_i && (mode_i != MODE_HOLD);
        cnt_nx  = st_q.cnt;
        down_nx = st_q.down;
        if (step) begin
            unique case (mode_i)
                MODE_UP: begin
                    cnt_nx = (st_q.cnt >= period_i) ? '0 : st_q.cnt + 1'b1;
                end
                MODE_DOWN: begin
                    cnt_nx = (st_q.cnt == '0 || st_q.cnt > period_i)
                             ? period_i : st_q.cnt - 1'b1;
                end
                MODE_UPDN: begin
                    if (period_i == '0) begin
                        cnt_nx = '0;
                    end else if (!st_q.down) begin
                        if (st_q.cnt >= period_i) begin
                            cnt_nx  = st_q.cnt - 1'b1;
                            down_nx = 1'b1;
                        end else begin
                            cnt_nx = st_q.cnt + 1'b1;
                        end
                    end else begin
                        if (st_q.cnt == '0) begin
                            cnt_nx  = st_q.cnt + 1'b1;
                            down_nx = 1'b0;
                        end else begin
                            cnt_nx = st_q.cnt - 1'b1;
                        end
                    end
                end
                default: begin
                    cnt_nx = st_q.cnt;
                end
            endcase
        end
    end

    assign wrap_o = step && (cnt_nx == '0);

    // Register image, strobes compared with the updated period
    always_comb begin
        st_d          = st_q;
        st_d.cnt      = cnt_nx;
        st_d.down     = dir_rst_i ? 1'b0 : down_nx;
        st_d.zero_evt = step && (cnt_nx == '0);
        st_d.prd_evt  = step && (cnt_nx == period_nx_i);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count_o    = st_q.cnt;
    assign zero_evt_o = st_q.zero_evt;
    assign prd_evt_o  = st_q.prd_evt;

endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase
    import pwm_tbase_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             wr_en_i,
    input  logic             wr_sel_i,
    input  logic [CNT_W-1:0] wr_data_i,
    output logic [CNT_W-1:0] count_o,
    output logic             zero_evt_o,
    output logic             prd_evt_o
);

    ctrl_t            ctrl_d, ctrl_q;
    logic             wr_ctrl;
    logic             wr_prd;
    logic             tick_w;
    logic             wrap_w;
    cnt_mode_e        mode_w;
    logic [CNT_W-1:0] prd_act_w;
    logic [CNT_W-1:0] prd_act_nx_w;
    logic [CNT_W-1:0] prd_shd_w;
    logic             ctrl_spare_unused;

    assign wr_ctrl = wr_en_i && !wr_sel_i;
    assign wr_prd  = wr_en_i &&  wr_sel_i;
    assign ctrl_spare_unused = ^{wr_data_i[CNT_W-1:DIVA_LSB+DIV_W],
                                 wr_data_i[DIVB_LSB-1:PLOAD_BIT+1],
                                 wr_data_i[PLOAD_BIT-1:MODE_LSB+2]};

    always_comb begin
        ctrl_d = ctrl_q;
        if (wr_ctrl) begin
            ctrl_d.mode   = cnt_mode_e'(wr_data_i[MODE_LSB +: 2]);
            ctrl_d.ld_imm = wr_data_i[PLOAD_BIT];
            ctrl_d.div_a  = wr_data_i[DIVA_LSB +: DIV_W];
            ctrl_d.div_b  = wr_data_i[DIVB_LSB +: DIV_W];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            ctrl_q      <= '0;
            ctrl_q.mode <= MODE_HOLD;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign mode_w = ctrl_q.mode;

    pwm_tbase_prescale #(
        .DIV_W (DIV_W)
    ) u_prescale (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .restart_i (wr_ctrl),
        .div_a_i   (ctrl_q.div_a),
        .div_b_i   (ctrl_q.div_b),
        .tick_o    (tick_w)
    );

    pwm_tbase_period #(
        .W (CNT_W)
    ) u_period (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .wr_i        (wr_prd),
        .imm_i       (ctrl_q.ld_imm),
        .data_i      (wr_data_i),
        .load_i      (wrap_w),
        .active_o    (prd_act_w),
        .active_nx_o (prd_act_nx_w),
        .shadow_o    (prd_shd_w)
    );

    pwm_tbase_counter #(
        .W (CNT_W)
    ) u_counter (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .tick_i      (tick_w),
        .mode_i      (mode_w),
        .dir_rst_i   (wr_ctrl),
        .period_i    (prd_act_w),
        .period_nx_i (prd_act_nx_w),
        .wrap_o      (wrap_w),
        .count_o     (count_o),
        .zero_evt_o  (zero_evt_o),
        .prd_evt_o   (prd_evt_o)
    );

endmodule

// File: rtl/pwm_timebase_chk.sv
module pwm_timebase_chk
    import pwm_tbase_pkg::*;
(
    input logic             clk_i,
    input logic             rst_ni,
    input logic             wr_en_i,
    input logic [CNT_W-1:0] count_o,
    input logic             zero_evt_o,
    input logic             prd_evt_o,
    input logic             tick_w,
    input cnt_mode_e        mode_w,
    input logic [CNT_W-1:0] prd_act_w,
    input logic [CNT_W-1:0] prd_shd_w
);

    AST_FREEZE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_w == MODE_HOLD) |=> $stable(count_o)); // R1

    AST_FREEZE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_w == MODE_HOLD) |=> (!zero_evt_o && !prd_evt_o)); // R1

    AST_UP_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick_w && mode_w == MODE_UP && count_o < prd_act_w)
        |=> (count_o == $past(count_o) + 16'd1)); // R2

    AST_DOWN_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick_w && mode_w == MODE_DOWN && count_o != '0 && count_o <= prd_act_w)
        |=> (count_o == $past(count_o) - 16'd1)); // R3

    AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !tick_w |=> ($stable(count_o) && !zero_evt_o && !prd_evt_o)); // R6

    AST_ZERO_EVT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        zero_evt_o |-> (count_o == '0)); // R7

    AST_PRD_EVT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        prd_evt_o |-> (count_o == prd_act_w)); // R7

    AST_SHADOW_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick_w && mode_w == MODE_UP && count_o >= prd_act_w && !wr_en_i)
        |=> (prd_act_w == $past(prd_shd_w))); // R8

endmodule

bind pwm_timebase pwm_timebase_chk u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .count_o    (count_o),
    .zero_evt_o (zero_evt_o),
    .prd_evt_o  (prd_evt_o),
    .tick_w     (tick_w),
    .mode_w     (mode_w),
    .prd_act_w  (prd_act_w),
    .prd_shd_w  (prd_shd_w)
);

// File: tb/test_pwm_timebase.sv
`timescale 1ns/1ps
module test_pwm_timebase;

    logic        clk_i = 1'b0;
    logic        rst_ni = 1'b0;
    logic        wr_en_i = 1'b0;
    logic        wr_sel_i = 1'b0;
    logic [15:0] wr_data_i = '0;
    logic [15:0] count_o;
    logic        zero_evt_o;
    logic        prd_evt_o;

    always #5 clk_i = ~clk_i;

    pwm_timebase i_pwm_timebase (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .wr_en_i    (wr_en_i),
        .wr_sel_i   (wr_sel_i),
        .wr_data_i  (wr_data_i),
        .count_o    (count_o),
        .zero_evt_o (zero_evt_o),
        .prd_evt_o  (prd_evt_o)
    );

    typedef struct {
        logic [15:0] cnt;
        bit          z;
        bit          p;
        string       req;
    } exp_t;

    exp_t  sb_q[$];
    int    n_chk  = 0;
    int    n_fail = 0;
    bit    done   = 0;
    string cur_req = "R10";

    // Reference model state, built from the requirements
    int m_cnt  = 0;
    bit m_down = 0;
    int m_act  = 0;
    int m_shd  = 0;
    int m_ph   = 0;
    int m_mode = 3;
    bit m_imm  = 0;
    int m_da   = 0;
    int m_db   = 0;

    task automatic step(input bit we, input bit sel, input logic [15:0] data);
        int  ratio;
        int  nxt;
        bit  ndown;
        bit  tk;
        bit  stepped;
        int  old_mode;
        bit  old_imm;
        exp_t e;
        @(negedge clk_i);
        wr_en_i   = we;
        wr_sel_i  = sel;
        wr_data_i = data;
        ratio    = (1 << m_da) * ((m_db == 0) ? 1 : 2 * m_db);
        tk       = (m_ph == ratio - 1);
        old_mode = m_mode;
        old_imm  = m_imm;
        stepped  = tk && (old_mode != 3);
        e.z = 0;
        e.p = 0;
        if (stepped) begin
            nxt   = m_cnt;
            ndown = m_down;
            case (old_mode)
                0: nxt = (m_cnt >= m_act) ? 0 : m_cnt + 1;
                1: nxt = (m_cnt == 0 || m_cnt > m_act) ? m_act : m_cnt - 1;
                default: begin
                    if (m_act == 0) nxt = 0;
                    else if (!m_down) begin
                        if (m_cnt >= m_act) begin nxt = m_cnt - 1; ndown = 1; end
                        else nxt = m_cnt + 1;
                    end else begin
                        if (m_cnt == 0) begin nxt = 1; ndown = 0; end
                        else nxt = m_cnt - 1;
                    end
                end
            endcase
            m_cnt  = nxt;
            m_down = ndown;
            if (nxt == 0) m_act = m_shd;
            e.z = (nxt == 0);
        end
        m_ph = tk ? 0 : m_ph + 1;
        if (we && !sel) begin
            m_mode = int'(data[1:0]);
            m_imm  = data[3];
            m_db   = int'(data[9:7]);
            m_da   = int'(data[12:10]);
            m_ph   = 0;
            m_down = 0;
        end
        if (we && sel) begin
            m_shd = int'(data);
            if (old_imm) m_act = int'(data);
        end
        if (stepped) e.p = (m_cnt == m_act);
        e.cnt = 16'(m_cnt);
        e.req = cur_req;
        sb_q.push_back(e);
        @(posedge clk_i);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 1'b0, 16'h0000);
    endtask

    task automatic wr_ctrl(input logic [15:0] d);
        step(1'b1, 1'b0, d);
    endtask

    task automatic wr_prd(input logic [15:0] d);
        step(1'b1, 1'b1, d);
    endtask

    // Monitor: compares each result one unit after the edge
    always @(posedge clk_i) begin
        #1;
        if (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            n_chk++;
            if (count_o !== e.cnt || zero_evt_o !== e.z || prd_evt_o !== e.p) begin
                n_fail++;
                $display("FAIL %s: count/zero/prd actual %0d/%0b/%0b expected %0d/%0b/%0b",
                         e.req, count_o, zero_evt_o, prd_evt_o, e.cnt, e.z, e.p);
            end
        end
    end

    initial begin
        #2000000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk_i);
        @(negedge clk_i);
        rst_ni = 1'b1;
        cur_req = "R10";   // reset state: frozen at 0, no strobes
        idle(5);
        cur_req = "R9";    // immediate period load
        wr_ctrl(16'h000B);
        wr_prd(16'd4);
        idle(3);
        cur_req = "R2";    // up, ratio 1, period 4
        wr_ctrl(16'h0008);
        idle(16);
        cur_req = "R1";    // freeze holds mid-count
        wr_ctrl(16'h000B);
        idle(6);
        cur_req = "R3";    // down
        wr_ctrl(16'h0009);
        idle(14);
        cur_req = "R4";    // up-down
        wr_ctrl(16'h000A);
        idle(20);
        cur_req = "R7";    // strobes with zero period in up mode
        wr_prd(16'd0);
        wr_ctrl(16'h0008);
        idle(4);
        wr_prd(16'd3);
        idle(10);
        cur_req = "R5";    // stage A ratio 4
        wr_ctrl(16'h0808);
        idle(40);
        cur_req = "R6";    // stage B ratio 6, then combined 2*2
        wr_ctrl(16'h0188);
        idle(50);
        wr_ctrl(16'h0488);
        idle(30);
        cur_req = "R11";   // control rewrite restarts the prescaler phase
        wr_ctrl(16'h0808);
        idle(2);
        wr_ctrl(16'h0808);
        idle(2);
        wr_prd(16'd3);
        idle(20);
        cur_req = "R8";    // shadowed period change while running
        wr_ctrl(16'h0000);
        idle(2);
        wr_prd(16'd7);
        idle(25);
        wr_ctrl(16'h0002); // up-down with shadow
        wr_prd(16'd2);
        idle(30);
        cur_req = "R6";    // largest ratio, 1792 cycles per tick
        wr_ctrl(16'h1F88);
        wr_prd(16'd1);
        idle(4000);
        wr_en_i = 1'b0;
        repeat (3) @(posedge clk_i);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule